// File: doc/BRIEF.md
# Concurrent Mark Engine with Snapshot Write Barrier

This block runs the trace phase of a snapshot-at-the-beginning garbage collector over a heap of uniform objects. Each object has one pointer field, and address 0 stands for null. Roots arrive one at a time from a snapshot engine. Each candidate pointer tests and sets its bit in a mark bitmap. A pointer that was not marked before goes into a mark FIFO. Each dequeued pointer is looked up in the pointer memory, and a non-null field it returns becomes a new candidate.

The mutator keeps a read/write port on the pointer memory that never stalls. When the mutator overwrites a non-null pointer during a trace, the old value is saved in a barrier register and marked, so every object reachable at the snapshot instant stays marked.

A sweep engine uses the block afterwards. It reads the mark bits through a query port and zeroes freed pointer fields through a clear port. A start pulse clears the bitmap and begins a trace. A one-cycle done pulse reports that the FIFO is empty and the pipeline has drained.

Top module: `gc_mark_engine`

## Requirements
- R1: After reset, done, busy and root_ready are 0 and every mark bit reads 0 on the query port.
- R2: A start pulse while idle clears every mark bit, and busy and root_ready are 1 in the following cycle.
- R3: A start pulse while busy is ignored: the mark bits set so far are kept and the trace completes normally.
- R4: When done pulses, a slot's mark bit is 1 exactly when the slot can be reached from an accepted root by following non-null pointer fields. A null root is accepted and marks nothing, and slot 0 is never marked.
- R5: A pointer enters the mark FIFO only when its mark bit was 0, so cycles in the heap (including self-pointers) terminate and the FIFO never holds more than N-1 entries.
- R6: A mutator access with mut_en=1 returns on mut_rdata, one cycle later, the contents of the addressed field before that access. A write (mut_we=1) updates the field, and the port never waits.
- R7: A busy-phase mutator write that replaces a non-null pointer captures the old value in the barrier register. The barrier register has priority over roots, so root_ready is 0 in the next cycle, and the overwritten target and its closure end up marked.
- R8: Termination: the cycle after a root is accepted, the FIFO pops it. If the fetched field is null, done rises on the second edge after root acceptance; if it is a non-null, already-marked pointer, done rises on the third edge.
- R9: done is a single-cycle pulse, and busy and root_ready are 0 from that cycle on.
- R10: clear_en=1 writes null into the pointer field at clear_addr, and a later mutator read of that field returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a trace (ignored while busy) |
| root_valid | input | 1 | A root pointer is offered |
| root_ptr | input | PTR_W | Root pointer value |
| roots_done | input | 1 | No further roots will follow the current one |
| root_ready | output | 1 | Root accepted at this clock edge |
| mut_en | input | 1 | Mutator access enable |
| mut_we | input | 1 | Mutator write (else read) |
| mut_addr | input | PTR_W | Mutator object address |
| mut_wdata | input | PTR_W | Pointer value to write |
| mut_rdata | output | PTR_W | Field contents before the last access |
| clear_en | input | 1 | Zero a pointer field (sweep) |
| clear_addr | input | PTR_W | Field to zero |
| q_addr | input | PTR_W | Mark bit query address |
| q_marked | output | 1 | Mark bit at q_addr |
| busy | output | 1 | Trace in progress |
| done | output | 1 | One-cycle trace completion pulse |

## Verification
If the test-and-set decision is wrong, the wrong set of slots shows as marked on the query port after done. A dropped barrier capture leaves the tail of a list unmarked. A duplicate enqueue makes done arrive late or not at all. A wrong drain condition moves done by one edge, and the exact single-root latency checks expose that. Mutator read data is compared against a behavioural heap on every access, so a barrier read that disturbs port timing or contents shows up in the next cycle.

// File: rtl/gc_mark_engine.sv
module gc_mark_engine #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             root_valid,
  input  logic [PTR_W-1:0] root_ptr,
  input  logic             roots_done,
  output logic             root_ready,
  input  logic             mut_en,
  input  logic             mut_we,
  input  logic [PTR_W-1:0] mut_addr,
  input  logic [PTR_W-1:0] mut_wdata,
  output logic [PTR_W-1:0] mut_rdata,
  input  logic             clear_en,
  input  logic [PTR_W-1:0] clear_addr,
  input  logic [PTR_W-1:0] q_addr,
  output logic             q_marked,
  output logic             busy,
  output logic             done
);
  localparam int N = 1 << PTR_W;

  logic [PTR_W-1:0] pmem [N];
  logic [PTR_W-1:0] fifo [N];
  logic [N-1:0]     mark;
  logic [PTR_W-1:0] wr_ix, rd_ix;
  logic [PTR_W:0]   cnt;
  logic             tracing, bar_v, f_v;
  logic [PTR_W-1:0] bar_ptr, f_ptr;

  logic             sel_v, f_take;
  logic [PTR_W-1:0] sel_ptr;

  wire             f_live  = f_v && (f_ptr != '0);
  wire             term    = tracing && roots_done && !root_valid && !bar_v && !f_live && (cnt == '0);
  wire [PTR_W-1:0] old_val = pmem[mut_addr];
  wire             cap     = tracing && !term && mut_en && mut_we && (old_val != '0);
  wire             f_free  = !f_live || f_take;
  wire             push    = tracing && sel_v && !mark[sel_ptr];
  wire             pop     = tracing && (cnt != '0) && f_free;

  assign root_ready = tracing && !bar_v;
  assign q_marked   = mark[q_addr];
  assign busy       = tracing;

  always_comb begin
    sel_v   = 1'b0;
    sel_ptr = '0;
    f_take  = 1'b0;
    if (bar_v) begin
      sel_v   = 1'b1;
      sel_ptr = bar_ptr;
    end else if (tracing && root_valid) begin
      sel_v   = (root_ptr != '0);
      sel_ptr = root_ptr;
    end else if (f_live) begin
      sel_v   = 1'b1;
      sel_ptr = f_ptr;
      f_take  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clear_en) pmem[clear_addr] <= '0;
    if (mut_en && mut_we) pmem[mut_addr] <= mut_wdata;
    if (mut_en) mut_rdata <= old_val;
    if (push) fifo[wr_ix] <= sel_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tracing <= 1'b0;
      done    <= 1'b0;
      mark    <= '0;
      wr_ix   <= '0;
      rd_ix   <= '0;
      cnt     <= '0;
      bar_v   <= 1'b0;
      bar_ptr <= '0;
      f_v     <= 1'b0;
      f_ptr   <= '0;
    end else begin
      done <= term;
      if (!tracing) begin
        if (start) begin
          tracing <= 1'b1;
          mark    <= '0;
          wr_ix   <= '0;
          rd_ix   <= '0;
          cnt     <= '0;
          bar_v   <= 1'b0;
          f_v     <= 1'b0;
        end
      end else begin
        if (term) tracing <= 1'b0;
        if (push) begin
          mark[sel_ptr] <= 1'b1;
          wr_ix         <= wr_ix + 1'b1;
        end
        if (pop) begin
          rd_ix <= rd_ix + 1'b1;
          f_v   <= 1'b1;
          f_ptr <= pmem[fifo[rd_ix]];
        end else if (f_free) begin
          f_v <= 1'b0;
        end
        cnt     <= cnt + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
        bar_v   <= cap;
        bar_ptr <= old_val;
      end
    end
  end
endmodule

// File: rtl/gc_mark_engine_chk.sv
module gc_mark_engine_chk #(
  parameter int PTR_W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           root_ready,
  input logic           cap,
  input logic           mark0,
  input logic [PTR_W:0] cnt
);
  localparam int N = 1 << PTR_W;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && !root_ready);
  p_start_enters_r2: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> busy);
  p_null_unmarked_r4: assert property (@(posedge clk) disable iff (!rst_n) !mark0);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n) cnt <= (PTR_W+1)'(N-1));
  p_barrier_first_r7: assert property (@(posedge clk) disable iff (!rst_n) cap |=> !root_ready);
endmodule

bind gc_mark_engine gc_mark_engine_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .root_ready(root_ready), .cap(cap), .mark0(mark[0]), .cnt(cnt)
);

// File: tb/gc_mark_engine_tb_top.sv
module gc_mark_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 6;
  localparam int NN = 1 << PW;

  logic clk = 0, rst_n = 0, start = 0, root_valid = 0, roots_done = 0;
  logic mut_en = 0, mut_we = 0, clear_en = 0;
  logic [PW-1:0] root_ptr = '0, mut_addr = '0, mut_wdata = '0, clear_addr = '0, q_addr = '0;
  logic [PW-1:0] mut_rdata;
  logic root_ready, q_marked, busy, done;

  int model [NN];
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gc_mark_engine #(.PTR_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .root_valid(root_valid), .root_ptr(root_ptr),
    .roots_done(roots_done), .root_ready(root_ready), .mut_en(mut_en), .mut_we(mut_we),
    .mut_addr(mut_addr), .mut_wdata(mut_wdata), .mut_rdata(mut_rdata), .clear_en(clear_en),
    .clear_addr(clear_addr), .q_addr(q_addr), .q_marked(q_marked), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1; cyc++;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mut(input bit we, input int a, input int d, input string tag);
    int exp;
    exp = model[a];
    mut_en = 1; mut_we = we; mut_addr = a[PW-1:0]; mut_wdata = d[PW-1:0];
    step();
    mut_en = 0; mut_we = 0;
    chk(mut_rdata == exp[PW-1:0], tag, mut_rdata, exp);
    if (we) model[a] = d;
  endtask

  function automatic logic [NN-1:0] reach(input int r[$]);
    logic [NN-1:0] m;
    int q[$];
    m = '0;
    foreach (r[i]) if (r[i] != 0 && !m[r[i]]) begin m[r[i]] = 1; q.push_back(r[i]); end
    while (q.size() > 0) begin
      int p;
      int n;
      p = q.pop_front();
      n = model[p];
      if (n != 0 && !m[n]) begin m[n] = 1; q.push_back(n); end
    end
    return m;
  endfunction

  task automatic get_marks(output logic [NN-1:0] v);
    for (int a = 0; a < NN; a++) begin
      q_addr = a[PW-1:0]; #1;
      v[a] = q_marked;
    end
  endtask

  task automatic begin_trace(input string tag);
    roots_done = 0; start = 1;
    step();
    start = 0;
    chk(busy && root_ready, tag, {busy, root_ready}, 2'b11);
  endtask

  task automatic feed_roots(input int r[$]);
    foreach (r[i]) begin
      bit ok;
      root_valid = 1; root_ptr = r[i][PW-1:0]; roots_done = (i == r.size() - 1);
      do begin ok = root_ready; step(); end while (!ok);
    end
    root_valid = 0; roots_done = 1;
  endtask

  task automatic wait_done(input string tag);
    int k;
    k = 0;
    while (!done && k < 3000) begin step(); k++; end
    chk(done, tag, done, 1);
    step();
    chk(!done && !busy && !root_ready, "R9 pulse ends", {done, busy, root_ready}, 0);
  endtask

  initial begin
    logic [NN-1:0] got, exp;
    int k;
    for (int i = 0; i < NN; i++) model[i] = 0;
    repeat (3) step();
    chk(!done && !busy && !root_ready, "R1 reset outputs", {done, busy, root_ready}, 0);
    rst_n = 1;
    step();
    get_marks(got);
    chk(got == '0, "R1 reset marks", got, 0);

    for (int i = 0; i < NN; i++) mut(1, i, 0, "R6 init write");
    mut(1, 1, 2, "R6 write"); mut(1, 2, 3, "R6 write");
    mut(1, 4, 5, "R6 write"); mut(1, 5, 4, "R6 write");
    mut(1, 6, 6, "R6 write"); mut(1, 7, 1, "R6 write");
    mut(1, 8, 9, "R6 write"); mut(0, 8, 0, "R6 read back");

    // R4 R5: lists, a two-node cycle, a self loop, an unreachable pair, null root
    begin_trace("R2 start enters trace");
    feed_roots('{7, 4, 0, 6});
    wait_done("R5 trace with cycles terminates");
    get_marks(got);
    exp = reach('{7, 4, 0, 6});
    chk(got == exp, "R4 closure of roots", got, exp);
    chk(!got[0] && !got[8] && !got[9], "R4 null and unreachable unmarked", got, exp);

    // R8 termination latency
    mut(1, 10, 0, "R6 write");
    mut(1, 11, 11, "R6 write");
    begin_trace("R2 start clears");
    get_marks(got);
    chk(got == '0, "R2 marks cleared by start", got, 0);
    root_valid = 1; root_ptr = 10; roots_done = 1;
    step();
    root_valid = 0;
    k = 0;
    while (!done && k < 20) begin step(); k++; end
    chk(k == 2, "R8 null field drain edges", k, 2);
    step();
    begin_trace("R2 start again");
    root_valid = 1; root_ptr = 11; roots_done = 1;
    step();
    root_valid = 0;
    k = 0;
    while (!done && k < 20) begin step(); k++; end
    chk(k == 3, "R8 non-null field drain edges", k, 3);
    step();

    // R7 barrier keeps snapshot
    for (int i = 20; i < 40; i++) mut(1, i, i + 1, "R6 write");
    mut(1, 40, 0, "R6 write");
    exp = reach('{20});
    begin_trace("R2 start barrier run");
    feed_roots('{20});
    mut(1, 35, 0, "R6 read old on write");
    chk(!root_ready && busy, "R7 barrier blocks roots", root_ready, 0);
    wait_done("R7 trace finishes");
    get_marks(got);
    chk(got == exp, "R7 snapshot closure kept", got, exp);

    // R3 start ignored during trace
    exp = reach('{20});
    begin_trace("R2 start for R3");
    feed_roots('{20});
    repeat (3) step();
    start = 1; step(); start = 0;
    wait_done("R3 trace completes");
    get_marks(got);
    chk(got == exp && got[20], "R3 marks kept after ignored start", got, exp);

    // R10 clear port
    clear_en = 1; clear_addr = 2;
    step();
    clear_en = 0; model[2] = 0;
    mut(0, 2, 0, "R10 cleared field reads null");
    mut(0, 1, 0, "R6 neighbour untouched");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule